// File: doc/BRIEF.md
# Receive Timeslot Store Engine

This engine sits behind a TDM receive port and turns its stream of 8-bit timeslot bytes into 64-bit word writes into a circular memory region. Bytes are packed into words in arrival order. Each superframe is a programmed number of slots and always starts on a fresh word. The region is measured in whole superframes. When the last superframe of the region has been issued, the write pointer returns to the region start.

The address of the next word and the superframe position inside the region are always visible. Three sticky status bits report events: frame-store, region-wrap and receive-overflow. A maskable interrupt line is driven from them. A frame-sync error input halts the engine. While halted, the address stays where the error hit.

The byte input uses a valid/ready pair, but a TDM port cannot wait. A byte offered while `in_ready` is low is lost and counted as an overflow. The write output is a valid/ready master. Once `wr_valid` rises, the address, data and enables are held until `wr_ready` accepts them. A stalled write backs up one word of packing before `in_ready` falls.

Top module: `rx_slot_store`

## Requirements
- R1: Bytes of a superframe fill word lanes from lane 0 (bits 7:0) upward. A word is issued after 8 bytes or after the last slot of a superframe, whichever comes first. `wr_be` has bit n set exactly for the filled lanes n, so the enables are always 1s from bit 0 upward. The next superframe starts in a new word.
- R2: Write addresses are byte addresses with bits 2:0 zero. The first word after enabling goes to `cfg_start` with its low 3 bits cleared, and each later word is 8 higher.
- R3: `next_addr` is the address the next issued word will use. `frame_pos` counts the superframes issued since the last wrap or restart.
- R4: Issuing the last word of superframe number `cfg_frames`-1 returns `next_addr` to the start, clears `frame_pos` and sets status bit 1 (wrap).
- R5: Status bit 0 (store) is set each time `cfg_ival` further superframes have been issued. A `cfg_ival` of 0 never sets it.
- R6: A byte offered with `in_valid` high while the engine runs and `in_ready` is low is dropped. It sets status bit 2 (overflow) and never appears in any written word.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_be` hold steady. `in_ready` falls once the packing word is full and the output word is stalled.
- R8: A pulse on `sync_err` while enabled discards the partly packed word and halts the engine until `enable` goes low. While halted, `in_ready` is low, `next_addr` does not move, and offered bytes are ignored without setting overflow.
- R9: Status bits are sticky. Writing 1 on an `irq_clr` bit clears that bit, and a new event in the same cycle wins. `irq` is high when any status bit with its `irq_en` bit set is high.
- R10: After reset, status is 0 and no write is pending. While `enable` is low, `in_ready` is low and `next_addr` equals the aligned start, one cycle after `enable` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run engine; low restarts pointers |
| sync_err | input | 1 | Frame-sync error pulse, halts engine |
| in_valid | input | 1 | Received slot byte present |
| in_ready | output | 1 | Engine can take a byte this cycle |
| in_data | input | 8 | Received slot byte |
| wr_valid | output | 1 | Word write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | AW | Byte address of the word |
| wr_data | output | 64 | Packed word |
| wr_be | output | 8 | Byte-lane enables |
| cfg_start | input | AW | Region start (low 3 bits ignored) |
| cfg_frames | input | FRM_W | Region length in superframes (nonzero) |
| cfg_slots | input | SLOT_W | Slots per superframe (nonzero) |
| cfg_ival | input | IVAL_W | Superframes per store event |
| next_addr | output | AW | Address of next word |
| frame_pos | output | FRM_W | Superframe position in region |
| irq_clr | input | 3 | Write-1-to-clear status |
| irq_en | input | 3 | Interrupt enables |
| irq_status | output | 3 | Sticky status: 0 store, 1 wrap, 2 overflow |
| irq | output | 1 | Interrupt line |

## Verification
The bench sweeps slot counts around the 8-byte word boundary: 1, 3, 8, 9, 16 and 20 slots. A design that miscounted lanes or kept packing across a superframe edge would write wrong enables, misplaced bytes or the wrong number of words. It checks that the pointer returns to the start after exactly the programmed number of superframes, and that a misaligned start address comes out aligned; an off-by-one in the region compare would overrun by a frame. It stalls the memory until the input is refused, so a design that let a refused byte into memory, or let the held word change, would fail on the written data. It raises a sync error partway through a word, so a design that flushed the partial word, advanced the pointer or flagged overflow while halted would be caught.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int unsigned LANES   = 8;
  localparam int unsigned LANE_W  = $clog2(LANES);
  localparam int unsigned WORD_W  = LANES * 8;
  localparam int unsigned NUM_IRQ = 3;
  localparam int unsigned IRQ_STORE = 0;
  localparam int unsigned IRQ_WRAP  = 1;
  localparam int unsigned IRQ_OVF   = 2;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [LANES-1:0]  be;
    logic              last;
  } rss_word_t;
endpackage

// File: rtl/rss_packer.sv
// Packs slot bytes into one word; tracks the slot position in the superframe.
module rss_packer
  import rss_pkg::*;
#(
  parameter int unsigned SLOT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic              take,
  output logic              done,
  output rss_word_t         word
);
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              done_d;
  rss_word_t         word_d;
  logic              frame_end;

  assign frame_end = ({1'b0, slot_q} + 1'b1) == {1'b0, cfg_slots};

  always_comb begin
    word_d = word;
    lane_d = lane_q;
    slot_d = slot_q;
    done_d = done;
    if (take) begin
      word_d = '0;
      lane_d = '0;
      done_d = 1'b0;
    end
    if (byte_vld) begin
      word_d.data[lane_d*8 +: 8] = byte_data;
      word_d.be[lane_d]          = 1'b1;
      if (frame_end) begin
        slot_d      = '0;
        done_d      = 1'b1;
        word_d.last = 1'b1;
      end else begin
        slot_d = slot_q + 1'b1;
        if (lane_d == LANE_W'(LANES - 1)) done_d = 1'b1;
      end
      lane_d = lane_d + 1'b1;
    end
    if (flush) begin
      word_d = '0;
      lane_d = '0;
      slot_d = '0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word   <= '0;
      lane_q <= '0;
      slot_q <= '0;
      done   <= 1'b0;
    end else begin
      word   <= word_d;
      lane_q <= lane_d;
      slot_q <= slot_d;
      done   <= done_d;
    end
  end
endmodule

// File: rtl/rss_addr_gen.sv
// Region write pointer, superframe position and store-interval counter.
module rss_addr_gen
  import rss_pkg::*;
#(
  parameter int unsigned AW     = 36,
  parameter int unsigned FRM_W  = 16,
  parameter int unsigned IVAL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              step_last,
  input  logic [AW-1:0]     cfg_start,
  input  logic [FRM_W-1:0]  cfg_frames,
  input  logic [IVAL_W-1:0] cfg_ival,
  output logic [AW-1:0]     addr_q,
  output logic [FRM_W-1:0]  frame_pos,
  output logic              wrap_evt,
  output logic              store_evt
);
  localparam logic [AW-1:0] STRIDE   = AW'(LANES);
  localparam logic [AW-1:0] LOW_MASK = AW'(LANES - 1);

  logic [AW-1:0]     base;
  logic [IVAL_W-1:0] ival_q;
  logic              frame_done;

  assign base       = cfg_start & ~LOW_MASK;
  assign frame_done = step & step_last;
  assign wrap_evt   = frame_done & (({1'b0, frame_pos} + 1'b1) == {1'b0, cfg_frames});
  assign store_evt  = frame_done & (({1'b0, ival_q} + 1'b1) == {1'b0, cfg_ival});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      frame_pos <= '0;
      ival_q    <= '0;
    end else if (load) begin
      addr_q    <= base;
      frame_pos <= '0;
      ival_q    <= '0;
    end else if (step) begin
      if (wrap_evt) begin
        addr_q    <= base;
        frame_pos <= '0;
      end else begin
        addr_q <= addr_q + STRIDE;
        if (step_last) frame_pos <= frame_pos + 1'b1;
      end
      if (step_last) ival_q <= store_evt ? '0 : ival_q + 1'b1;
    end
  end
endmodule

// File: rtl/rss_irq.sv
// Sticky write-1-to-clear status with masked interrupt line.
module rss_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] status,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | set;
  end

  assign irq = |(status & en);
endmodule

// File: rtl/rx_slot_store.sv
// Receive timeslot store engine: packs slot bytes and writes them to a ring.
module rx_slot_store
  import rss_pkg::*;
#(
  parameter int unsigned AW     = 36,
  parameter int unsigned SLOT_W = 10,
  parameter int unsigned FRM_W  = 16,
  parameter int unsigned IVAL_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sync_err,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [AW-1:0]      wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic [LANES-1:0]   wr_be,
  input  logic [AW-1:0]      cfg_start,
  input  logic [FRM_W-1:0]   cfg_frames,
  input  logic [SLOT_W-1:0]  cfg_slots,
  input  logic [IVAL_W-1:0]  cfg_ival,
  output logic [AW-1:0]      next_addr,
  output logic [FRM_W-1:0]   frame_pos,
  input  logic [NUM_IRQ-1:0] irq_clr,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic [NUM_IRQ-1:0] irq_status,
  output logic               irq
);
  logic               halted_q;
  logic               running;
  logic               out_free;
  logic               accept;
  logic               take;
  logic               flush;
  logic               asm_done;
  rss_word_t          asm_word;
  logic               wrap_evt;
  logic               store_evt;
  logic               ovf_evt;
  logic [NUM_IRQ-1:0] irq_set;

  // A sync error halts until software drops enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halted_q <= 1'b0;
    else if (!enable)  halted_q <= 1'b0;
    else if (sync_err) halted_q <= 1'b1;
  end

  assign running  = enable & ~halted_q;
  assign out_free = ~wr_valid | wr_ready;
  assign in_ready = running & (~asm_done | out_free);
  assign accept   = in_valid & in_ready & ~sync_err;
  assign take     = asm_done & out_free & running & ~sync_err;
  assign flush    = ~running | sync_err;
  assign ovf_evt  = running & in_valid & ~in_ready;

  rss_packer #(.SLOT_W(SLOT_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .byte_vld  (accept),
    .byte_data (in_data),
    .cfg_slots (cfg_slots),
    .take      (take),
    .done      (asm_done),
    .word      (asm_word)
  );

  rss_addr_gen #(.AW(AW), .FRM_W(FRM_W), .IVAL_W(IVAL_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (~enable),
    .step       (take),
    .step_last  (asm_word.last),
    .cfg_start  (cfg_start),
    .cfg_frames (cfg_frames),
    .cfg_ival   (cfg_ival),
    .addr_q     (next_addr),
    .frame_pos  (frame_pos),
    .wrap_evt   (wrap_evt),
    .store_evt  (store_evt)
  );

  // Output word register: loaded on take, held until accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else if (take) begin
      wr_valid <= 1'b1;
      wr_addr  <= next_addr;
      wr_data  <= asm_word.data;
      wr_be    <= asm_word.be;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_STORE] = store_evt;
    irq_set[IRQ_WRAP]  = wrap_evt;
    irq_set[IRQ_OVF]   = ovf_evt;
  end

  rss_irq #(.N(NUM_IRQ)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (irq_set),
    .clr    (irq_clr),
    .en     (irq_en),
    .status (irq_status),
    .irq    (irq)
  );
endmodule

// File: rtl/rss_checker.sv
module rss_checker
  import rss_pkg::*;
#(
  parameter int unsigned AW = 36
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               halted,
  input logic               in_valid,
  input logic               in_ready,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [AW-1:0]      wr_addr,
  input logic [WORD_W-1:0]  wr_data,
  input logic [LANES-1:0]   wr_be,
  input logic [AW-1:0]      next_addr,
  input logic [NUM_IRQ-1:0] irq_clr,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic [NUM_IRQ-1:0] irq_status,
  input logic               irq
);
  p_be_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_be[0] && ((LANES'(wr_be + 1'b1) & wr_be) == '0)));

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[2:0] == 3'b000));

  p_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !halted && in_valid && !in_ready) |=> irq_status[IRQ_OVF]);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

  p_halt_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !in_ready);

  p_halt_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && halted && $past(enable) && $past(halted)) |-> $stable(next_addr));

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_status[IRQ_WRAP]) && !$past(irq_clr[IRQ_WRAP])) |-> irq_status[IRQ_WRAP]);
endmodule

bind rx_slot_store rss_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .halted     (halted_q),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_be      (wr_be),
  .next_addr  (next_addr),
  .irq_clr    (irq_clr),
  .irq_en     (irq_en),
  .irq_status (irq_status),
  .irq        (irq)
);

// File: tb/rx_slot_store_tb_top.sv
`timescale 1ns/1ps
module rx_slot_store_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, sync_err = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        wr_valid, wr_ready = 1'b1;
  logic [35:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;
  logic [35:0] cfg_start = '0;
  logic [15:0] cfg_frames = 16'd2;
  logic [9:0]  cfg_slots = 10'd1, cfg_ival = 10'd1;
  logic [35:0] next_addr;
  logic [15:0] frame_pos;
  logic [2:0]  irq_clr = '0, irq_en = '0, irq_status;
  logic        irq;

  int n_checks = 0, n_errs = 0;
  logic [35:0] lg_addr [64];
  logic [63:0] lg_data [64];
  logic [7:0]  lg_be   [64];
  int lg_n = 0;

  always #2.5 clk = ~clk;

  rx_slot_store dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_err(sync_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .cfg_start(cfg_start),
    .cfg_frames(cfg_frames), .cfg_slots(cfg_slots), .cfg_ival(cfg_ival),
    .next_addr(next_addr), .frame_pos(frame_pos), .irq_clr(irq_clr),
    .irq_en(irq_en), .irq_status(irq_status), .irq(irq)
  );

  // Record each write handshake that will complete at the next edge.
  always @(negedge clk) begin
    if (wr_valid && wr_ready && lg_n < 64) begin
      lg_addr[lg_n] = wr_addr;
      lg_data[lg_n] = wr_data;
      lg_be[lg_n]   = wr_be;
      lg_n = lg_n + 1;
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b; tick; in_valid = 1'b0;
  endtask

  task automatic restart;
    enable = 1'b0; irq_clr = '1; wr_ready = 1'b1;
    tick; tick;
    irq_clr = '0; lg_n = 0; enable = 1'b1;
    tick;
  endtask

  task automatic settle;
    repeat (4) tick;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int r, input int f, input int s);
    return 8'((r * 29 + f * 53 + s * 7 + 3) & 255);
  endfunction

  // Rows: slots per superframe, expected words per superframe, last-word enables.
  localparam logic [25:0] VEC [6] = '{
    {10'd1,  8'd1, 8'h01},
    {10'd3,  8'd1, 8'h07},
    {10'd8,  8'd1, 8'hFF},
    {10'd9,  8'd2, 8'h01},
    {10'd16, 8'd2, 8'hFF},
    {10'd20, 8'd3, 8'h0F}
  };

  localparam logic [35:0] BASE = 36'h0_0001_0000;

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    // Reset state (R10)
    cfg_start = 36'h0_0000_1235;
    repeat (3) tick;
    @(negedge clk);
    chk("R10 wr_valid in reset", {63'd0, wr_valid}, 64'd0);
    chk("R10 status in reset", {61'd0, irq_status}, 64'd0);
    chk("R10 in_ready in reset", {63'd0, in_ready}, 64'd0);
    rst_n = 1'b1;
    tick; tick;
    @(negedge clk);
    chk("R10/R2 next_addr aligned start while disabled", {28'd0, next_addr}, 64'h1230);

    // Table walk (R1, R2, R4, R5)
    for (int r = 0; r < 6; r++) begin
      int slots, words;
      logic [7:0] lbe;
      slots = int'(VEC[r][25:16]);
      words = int'(VEC[r][15:8]);
      lbe   = VEC[r][7:0];
      cfg_start = BASE; cfg_slots = VEC[r][25:16]; cfg_frames = 16'd2; cfg_ival = 10'd1;
      restart;
      for (int f = 0; f < 2; f++)
        for (int s = 0; s < slots; s++) send_byte(pat(r, f, s));
      settle;
      chk("R1 word count", 64'(lg_n), 64'(2 * words));
      for (int k = 0; k < 2 * words && k < 64; k++) begin
        int f, w;
        logic [7:0]  eb;
        logic [63:0] ed, msk;
        f = k / words; w = k % words;
        eb = (w == words - 1) ? lbe : 8'hFF;
        ed = '0; msk = '0;
        for (int l = 0; l < 8; l++)
          if (eb[l]) begin
            ed[l*8 +: 8] = pat(r, f, w * 8 + l);
            msk[l*8 +: 8] = 8'hFF;
          end
        chk("R2 word address", {28'd0, lg_addr[k]}, {28'd0, BASE + 36'(8 * k)});
        chk("R1 byte enables", {56'd0, lg_be[k]}, {56'd0, eb});
        chk("R1 packed data", lg_data[k] & msk, ed);
      end
      chk("R4 next_addr back at start", {28'd0, next_addr}, {28'd0, BASE});
      chk("R4 frame_pos cleared", {48'd0, frame_pos}, 64'd0);
      chk("R4 wrap status", {63'd0, irq_status[1]}, 64'd1);
      chk("R5 store status", {63'd0, irq_status[0]}, 64'd1);
    end

    // Misaligned start, store interval, mask and clear (R2, R3, R5, R9, R4)
    cfg_start = 36'h0_0000_1235; cfg_slots = 10'd4; cfg_frames = 16'd4; cfg_ival = 10'd2;
    restart;
    for (int s = 0; s < 4; s++) send_byte(8'(s));
    settle;
    chk("R2 first address aligned", {28'd0, lg_addr[0]}, 64'h1230);
    chk("R3 next_addr after one frame", {28'd0, next_addr}, 64'h1238);
    chk("R3 frame_pos after one frame", {48'd0, frame_pos}, 64'd1);
    chk("R5 no store before interval", {63'd0, irq_status[0]}, 64'd0);
    for (int s = 0; s < 4; s++) send_byte(8'(s));
    settle;
    chk("R5 store after interval", {63'd0, irq_status[0]}, 64'd1);
    chk("R4 no wrap mid region", {63'd0, irq_status[1]}, 64'd0);
    chk("R9 irq masked", {63'd0, irq}, 64'd0);
    irq_en = 3'b001; tick; @(negedge clk);
    chk("R9 irq enabled", {63'd0, irq}, 64'd1);
    irq_clr = 3'b001; tick; irq_clr = '0; @(negedge clk);
    chk("R9 write-1 clear", {63'd0, irq_status[0]}, 64'd0);
    chk("R9 irq after clear", {63'd0, irq}, 64'd0);
    irq_en = '0;
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 4; s++) send_byte(8'(s));
    settle;
    chk("R4 wrap to aligned start", {28'd0, next_addr}, 64'h1230);
    chk("R4 wrap status after 4 frames", {63'd0, irq_status[1]}, 64'd1);

    // Overflow under write back-pressure (R6, R7, R5)
    cfg_start = BASE; cfg_slots = 10'd8; cfg_frames = 16'd4; cfg_ival = 10'd0;
    restart;
    wr_ready = 1'b0;
    for (int i = 0; i < 16; i++) send_byte(8'(8'h10 + i));
    @(negedge clk);
    chk("R7 in_ready low when both words full", {63'd0, in_ready}, 64'd0);
    chk("R7 wr_valid held", {63'd0, wr_valid}, 64'd1);
    chk("R7 wr_addr held", {28'd0, wr_addr}, {28'd0, BASE});
    send_byte(8'hEE);
    @(negedge clk);
    chk("R6 overflow status", {63'd0, irq_status[2]}, 64'd1);
    chk("R7 wr_data held", wr_data, 64'h1716151413121110);
    wr_ready = 1'b1;
    settle;
    chk("R6 two words written", 64'(lg_n), 64'd2);
    chk("R6 dropped byte absent", lg_data[1], 64'h1F1E1D1C1B1A1918);
    chk("R5 zero interval never stores", {63'd0, irq_status[0]}, 64'd0);

    // Sync error halt (R8, R10)
    cfg_start = BASE; cfg_slots = 10'd8; cfg_frames = 16'd4; cfg_ival = 10'd1;
    restart;
    for (int i = 0; i < 8; i++) send_byte(8'(i));
    for (int i = 0; i < 3; i++) send_byte(8'hA0);
    settle;
    sync_err = 1'b1; tick; sync_err = 1'b0;
    @(negedge clk);
    chk("R8 next_addr at error point", {28'd0, next_addr}, {28'd0, BASE + 36'd8});
    chk("R8 in_ready low when halted", {63'd0, in_ready}, 64'd0);
    for (int i = 0; i < 6; i++) send_byte(8'hB0);
    settle;
    chk("R8 partial word discarded", 64'(lg_n), 64'd1);
    chk("R8 no overflow while halted", {63'd0, irq_status[2]}, 64'd0);
    chk("R8 next_addr still held", {28'd0, next_addr}, {28'd0, BASE + 36'd8});
    enable = 1'b0; tick; @(negedge clk);
    chk("R10 disable reloads start", {28'd0, next_addr}, {28'd0, BASE});

    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule